// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a host I/O port pair and a PCI master. The host first writes a 32-bit configuration address word through an address port. A later host read or write of a separate data port is turned into the address phase of one PCI transaction. That address phase is a registered address value, a bus command code and a one-hot IDSEL vector. The block picks one of four cycle kinds: local configuration (type 0), forwarded configuration (type 1), special cycle, or plain I/O pass-through when translation is off.

The stored word has these fields. Bit 31 turns translation on. Bits 23:16 give the bus number, bits 15:11 the device number, bits 10:8 the function and bits 7:2 the dword register index. Bits 30:24 and 1:0 are kept but not used. The bridge itself is on bus zero.

The host side is a single-cycle request strobe with an acknowledge pulse one cycle later. After a data-port request, a busy flag blocks any further host requests until the downstream side acknowledges the address phase.

Top module: `pci_cfg_xlate`

## Requirements
- R1: While reset is low, and on the first cycle after it, `host_busy`, `ap_valid` and `host_ack` are 0, `host_rdata` is 0 and the stored address word is 0.
- R2: If bit 31 of the stored word is 0, a data-port access gives `ap_kind`=0 (I/O). The address is the parameter `DATA_PORT_ADDR`, the command is 0010 for a read or 0011 for a write, and `ap_idsel` is 0.
- R3: For a type 0 cycle (`ap_kind`=1), `ap_addr[10:8]` is the function field, `ap_addr[7:2]` is the register field and `ap_addr[1:0]` is 00, whatever stored bits 1:0 hold.
- R4: For a type 0 cycle, device 0x0B to 0x1E asserts `ap_addr` bit 11 to 30 (the same bit number as the device value), and device 0x00 asserts bit 31. `ap_idsel[i]` equals `ap_addr[11+i]`, and at most one IDSEL bit is ever high.
- R5: Device values 0x01 to 0x0A and 0x1F drive `ap_addr[31:11]` and `ap_idsel` all zero in a type 0 cycle.
- R6: A nonzero bus field with translation on gives a type 1 cycle (`ap_kind`=2). The address is {8'h00, stored bits 23:2, 2'b01} and `ap_idsel` is 0.
- R7: A data-port write with translation on, bus 0, device 0x1F, function 7 and register 0 gives a special cycle (`ap_kind`=3). The command is 0001, the address is 32'h0000FF00 and `ap_idsel` is 0. A read with the same fields is a type 0 read that drives no IDSEL.
- R8: The command for type 0 and type 1 cycles is 1010 for a read and 1011 for a write.
- R9: A data-port request taken in cycle N (`host_req` high while `host_busy` is low) makes `ap_valid` high in cycle N+1 only. `host_busy` rises in cycle N+1 and stays high until the cycle after `ds_ack` is seen while busy. Requests made while busy get no acknowledge, change no state and create no cycle.
- R10: Every accepted request pulses `host_ack` in the next cycle. An address-port write stores all 32 bits and creates no PCI cycle. An address-port read loads the stored word into `host_rdata`, which holds it until the next address-port read.
- R11: Stored bits 30:24 read back as written but do not change the kind, address, command or IDSEL of any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host request strobe, one cycle |
| host_sel_data | input | 1 | 1 = data port, 0 = address port |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | Acknowledge pulse, one cycle after acceptance |
| host_rdata | output | 32 | Last address-port read value |
| host_busy | output | 1 | Address phase outstanding, requests blocked |
| ds_ack | input | 1 | Downstream acknowledge of the address phase |
| ap_valid | output | 1 | Address phase valid, one cycle |
| ap_kind | output | 2 | 0 I/O, 1 type 0, 2 type 1, 3 special |
| ap_addr | output | 32 | AD value for the address phase |
| ap_cbe | output | 4 | Bus command code |
| ap_idsel | output | 21 | One-hot IDSEL, bit i mirrors AD[11+i] |

## Verification
The assertions assume the host drives `host_req` for one cycle per operation, and that `ds_ack` matters only while `host_busy` is high. They also assume `ap_kind` is read only in a cycle where `ap_valid` is high. The stimulus drives each request for exactly one clock. It raises `ds_ack` after varied delays, and also while the block is idle, to show that the idle case is ignored. It also issues requests on purpose while busy, to check that they are dropped. Address words sweep all 32 device values, nonzero bus numbers, the special-cycle pattern for both reads and writes, translation off, and set reserved and low bits. A reference model in the bench follows every clock.

// File: rtl/pci_xlate_pkg.sv
// Shared types and command codes for the PCI configuration address translator.
// Assumes a 32-bit AD bus and the standard PCI command encodings.
package pci_xlate_pkg;

    typedef enum logic [1:0] {
        AP_IO      = 2'd0,
        AP_CFG0    = 2'd1,
        AP_CFG1    = 2'd2,
        AP_SPECIAL = 2'd3
    } ap_kind_t;

    localparam logic [3:0] CMD_IO_RD   = 4'b0010;
    localparam logic [3:0] CMD_IO_WR   = 4'b0011;
    localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
    localparam logic [3:0] CMD_SPECIAL = 4'b0001;

    // Field layout of the stored configuration address word (bit positions are decoded).
    typedef struct packed {
        logic       xlate_on;
        logic [6:0] spare;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] dword;
        logic [1:0] low;
    } cfg_word_t;

endpackage

// File: rtl/pci_cfg_word_reg.sv
// Holds the 32-bit configuration address word written by the host.
// Assumes the caller qualifies wr_en with its own acceptance logic.
module pci_cfg_word_reg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q
);

    // Store the whole word on an accepted write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/pci_idsel_decode.sv
// Decodes the device number into a one-hot IDSEL vector covering AD[IDSEL_LO..31].
// The top bit is selected by device 0; every other bit i is selected by the device
// value IDSEL_LO+i. Every remaining device value gives an all-zero vector.
module pci_idsel_decode #(
    parameter int DEV_W    = 5,
    parameter int AD_W     = 32,
    parameter int IDSEL_LO = 11
) (
    input  logic [DEV_W-1:0]         dev,
    output logic [AD_W-IDSEL_LO-1:0] onehot
);

    localparam int IDSEL_N = AD_W - IDSEL_LO;

    for (genvar i = 0; i < IDSEL_N; i++) begin : g_line
        if (i == IDSEL_N - 1) begin : g_top
            // Highest IDSEL line is reached by device zero.
            assign onehot[i] = (dev == '0);
        end else begin : g_lin
            // Remaining lines follow the device value directly.
            assign onehot[i] = (dev == DEV_W'(IDSEL_LO + i));
        end
    end

endmodule

// File: rtl/pci_ap_builder.sv
// Combinational translation of the stored word plus read/write direction into
// cycle kind, AD address value, command code and IDSEL. Assumes AD is 32 bits.
module pci_ap_builder
    import pci_xlate_pkg::*;
#(
    parameter logic [31:0] DATA_PORT_ADDR = 32'h0000_0CFC,
    parameter int          IDSEL_LO       = 11
) (
    input  cfg_word_t               cfg,
    input  logic                    we,
    input  logic [31-IDSEL_LO:0]    onehot,
    output ap_kind_t                kind,
    output logic [31:0]             addr,
    output logic [3:0]              cbe,
    output logic [31-IDSEL_LO:0]    idsel
);

    logic special_pat;

    // Recognise the broadcast pattern: local bus, all-ones device and function, dword 0.
    always_comb begin
        special_pat = (cfg.bus == 8'h00) && (&cfg.dev) && (&cfg.fn) && (cfg.dword == 6'd0);
    end

    // Pick the cycle kind and assemble the address-phase fields.
    always_comb begin
        kind  = AP_IO;
        addr  = DATA_PORT_ADDR;
        cbe   = we ? CMD_IO_WR : CMD_IO_RD;
        idsel = '0;
        if (cfg.xlate_on) begin
            if (cfg.bus != 8'h00) begin
                kind = AP_CFG1;
                addr = {8'h00, cfg.bus, cfg.dev, cfg.fn, cfg.dword, 2'b01};
                cbe  = we ? CMD_CFG_WR : CMD_CFG_RD;
            end else if (we && special_pat) begin
                kind = AP_SPECIAL;
                addr = {8'h00, cfg.bus, cfg.dev, cfg.fn, cfg.dword, 2'b00};
                cbe  = CMD_SPECIAL;
            end else begin
                kind  = AP_CFG0;
                addr  = {onehot, cfg.fn, cfg.dword, 2'b00};
                cbe   = we ? CMD_CFG_WR : CMD_CFG_RD;
                idsel = onehot;
            end
        end
    end

endmodule

// File: rtl/pci_cfg_xlate.sv
// PCI configuration address translator top. Accepts single-cycle host requests on an
// address port and a data port. Address-port accesses reach the stored word. Data-port
// accesses produce a registered one-cycle address phase and hold busy until ds_ack.
// Assumes host_req is a one-cycle strobe and ds_ack matters only while busy.
module pci_cfg_xlate
    import pci_xlate_pkg::*;
#(
    parameter logic [31:0] DATA_PORT_ADDR = 32'h0000_0CFC,
    parameter int          IDSEL_LO       = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_req,
    input  logic                  host_sel_data,
    input  logic                  host_we,
    input  logic [31:0]           host_wdata,
    output logic                  host_ack,
    output logic [31:0]           host_rdata,
    output logic                  host_busy,
    input  logic                  ds_ack,
    output logic                  ap_valid,
    output logic [1:0]            ap_kind,
    output logic [31:0]           ap_addr,
    output logic [3:0]            ap_cbe,
    output logic [31-IDSEL_LO:0]  ap_idsel
);

    localparam int IDSEL_N = 32 - IDSEL_LO;

    logic               accept;
    logic               data_go;
    logic               word_wr;
    logic               word_rd;
    logic [31:0]        word_q;
    cfg_word_t          cfg;
    logic [IDSEL_N-1:0] onehot;
    ap_kind_t           nx_kind;
    logic [31:0]        nx_addr;
    logic [3:0]         nx_cbe;
    logic [IDSEL_N-1:0] nx_idsel;
    logic               busy_q;

    // Qualify host requests against the busy flag and split them by port and direction.
    always_comb begin
        accept  = host_req && !busy_q;
        data_go = accept && host_sel_data;
        word_wr = accept && !host_sel_data && host_we;
        word_rd = accept && !host_sel_data && !host_we;
        cfg     = cfg_word_t'(word_q);
    end

    pci_cfg_word_reg #(.WORD_W(32)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (word_wr),
        .wdata (host_wdata),
        .q     (word_q)
    );

    pci_idsel_decode #(.DEV_W(5), .AD_W(32), .IDSEL_LO(IDSEL_LO)) u_idsel (
        .dev    (cfg.dev),
        .onehot (onehot)
    );

    pci_ap_builder #(.DATA_PORT_ADDR(DATA_PORT_ADDR), .IDSEL_LO(IDSEL_LO)) u_build (
        .cfg    (cfg),
        .we     (host_we),
        .onehot (onehot),
        .kind   (nx_kind),
        .addr   (nx_addr),
        .cbe    (nx_cbe),
        .idsel  (nx_idsel)
    );

    // Busy rises with a data-port request and falls after the downstream acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (data_go) begin
            busy_q <= 1'b1;
        end else if (busy_q && ds_ack) begin
            busy_q <= 1'b0;
        end
    end

    // Register the address phase and pulse its valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ap_valid <= 1'b0;
            ap_kind  <= 2'd0;
            ap_addr  <= '0;
            ap_cbe   <= '0;
            ap_idsel <= '0;
        end else begin
            ap_valid <= data_go;
            if (data_go) begin
                ap_kind  <= nx_kind;
                ap_addr  <= nx_addr;
                ap_cbe   <= nx_cbe;
                ap_idsel <= nx_idsel;
            end
        end
    end

    // Acknowledge every accepted request and capture address-port read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ack   <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ack <= accept;
            if (word_rd) begin
                host_rdata <= word_q;
            end
        end
    end

    assign host_busy = busy_q;

endmodule

// File: rtl/pci_cfg_xlate_chk.sv
// Assertion checker for pci_cfg_xlate, attached by bind. Assumes one-cycle host
// strobes and that ap_kind is meaningful only while ap_valid is high.
module pci_cfg_xlate_chk #(
    parameter int IDSEL_LO = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  host_req,
    input logic                  host_ack,
    input logic                  host_busy,
    input logic                  ds_ack,
    input logic                  ap_valid,
    input logic [1:0]            ap_kind,
    input logic [31:0]           ap_addr,
    input logic [3:0]            ap_cbe,
    input logic [31-IDSEL_LO:0]  ap_idsel
);

    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        ap_valid |=> !ap_valid);

    a_r9_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ap_valid |-> host_busy);

    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy && !ds_ack) |=> host_busy);

    a_r4_idsel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ap_idsel));

    a_r3_cfg0_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_valid && ap_kind == 2'd1) |-> (ap_addr[1:0] == 2'b00 && ap_addr[31:IDSEL_LO] == ap_idsel));

    a_r6_cfg1_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_valid && ap_kind == 2'd2) |-> (ap_addr[1:0] == 2'b01 && ap_addr[31:24] == 8'h00 && ap_idsel == '0));

    a_r8_cfg_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_valid && (ap_kind == 2'd1 || ap_kind == 2'd2)) |-> (ap_cbe[3:1] == 3'b101));

    a_r10_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> $past(host_req && !host_busy));

endmodule

bind pci_cfg_xlate pci_cfg_xlate_chk #(.IDSEL_LO(IDSEL_LO)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_req  (host_req),
    .host_ack  (host_ack),
    .host_busy (host_busy),
    .ds_ack    (ds_ack),
    .ap_valid  (ap_valid),
    .ap_kind   (ap_kind),
    .ap_addr   (ap_addr),
    .ap_cbe    (ap_cbe),
    .ap_idsel  (ap_idsel)
);

// File: tb/pci_cfg_xlate_tb_top.sv
// Bench for pci_cfg_xlate: behavioural reference model stepped on every rising edge
// and compared against the outputs on every falling edge.
module pci_cfg_xlate_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] IO_PORT    = 32'h0000_0CFC;
    localparam int          WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_sel_data = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        ds_ack = 1'b0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        host_busy;
    logic        ap_valid;
    logic [1:0]  ap_kind;
    logic [31:0] ap_addr;
    logic [3:0]  ap_cbe;
    logic [20:0] ap_idsel;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_word = '0;
    logic        m_busy = 1'b0;
    logic        m_valid = 1'b0;
    logic        m_ack = 1'b0;
    logic [31:0] m_rdata = '0;
    int          m_kind = 0;
    logic [31:0] m_addr = '0;
    logic [3:0]  m_cbe = '0;
    logic [20:0] m_idsel = '0;
    bit          m_after_reset = 1'b1;

    pci_cfg_xlate dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_req      (host_req),
        .host_sel_data (host_sel_data),
        .host_we       (host_we),
        .host_wdata    (host_wdata),
        .host_ack      (host_ack),
        .host_rdata    (host_rdata),
        .host_busy     (host_busy),
        .ds_ack        (ds_ack),
        .ap_valid      (ap_valid),
        .ap_kind       (ap_kind),
        .ap_addr       (ap_addr),
        .ap_cbe        (ap_cbe),
        .ap_idsel      (ap_idsel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Translate a stored word and direction into the expected address phase.
    task automatic predict(input logic [31:0] w, input logic wr);
        int dev, fn, rg, bus;
        logic [20:0] sel;
        dev = int'(w[15:11]);
        fn  = int'(w[10:8]);
        rg  = int'(w[7:2]);
        bus = int'(w[23:16]);
        sel = '0;
        if (dev == 0) sel = 21'h1 << 20;
        else if (dev >= 11 && dev <= 30) sel = 21'h1 << (dev - 11);
        m_idsel = '0;
        if (!w[31]) begin
            m_kind = 0; m_addr = IO_PORT; m_cbe = wr ? 4'b0011 : 4'b0010;
        end else if (bus != 0) begin
            m_kind = 2; m_cbe = wr ? 4'b1011 : 4'b1010;
            m_addr = (bus << 16) | (dev << 11) | (fn << 8) | (rg << 2) | 1;
        end else if (wr && dev == 31 && fn == 7 && rg == 0) begin
            m_kind = 3; m_cbe = 4'b0001; m_addr = 32'h0000_FF00;
        end else begin
            m_kind = 1; m_cbe = wr ? 4'b1011 : 4'b1010; m_idsel = sel;
            m_addr = ({11'h0, sel} << 11) | (fn << 8) | (rg << 2);
        end
    endtask

    // Step the reference model on each rising edge from the current inputs.
    always @(posedge clk) begin
        bit take;
        if (!rst_n) begin
            m_word = '0; m_busy = 0; m_valid = 0; m_ack = 0; m_rdata = '0;
            m_kind = 0; m_addr = '0; m_cbe = '0; m_idsel = '0;
            m_after_reset = 1'b1;
        end else begin
            m_after_reset = 1'b0;
            take = host_req && !m_busy;
            m_ack = take;
            m_valid = 1'b0;
            if (m_busy && ds_ack) m_busy = 1'b0;
            if (take && host_sel_data) begin
                predict(m_word, host_we);
                m_valid = 1'b1;
                m_busy = 1'b1;
            end else if (take && host_we) begin
                m_word = host_wdata;
            end else if (take) begin
                m_rdata = m_word;
            end
        end
    end

    function automatic string addr_tag(int k);
        case (k)
            0: return "R2";
            1: return "R3/R4/R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cycles, act, exp);
        end
    endtask

    // Compare all outputs away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (!rst_n || m_after_reset) begin
            chk("R1 busy", 32'(host_busy), 32'(0));
            chk("R1 valid", 32'(ap_valid), 32'(0));
            chk("R1 rdata", host_rdata, 32'h0);
        end else begin
            chk("R9 busy", 32'(host_busy), 32'(m_busy));
            chk("R9 valid", 32'(ap_valid), 32'(m_valid));
            chk("R10 ack", 32'(host_ack), 32'(m_ack));
            chk("R10/R11 rdata", host_rdata, m_rdata);
            if (m_valid) begin
                chk("R2/R6/R7 kind", 32'(ap_kind), 32'(m_kind));
                chk(addr_tag(m_kind), ap_addr, m_addr);
                chk("R8 cbe", 32'(ap_cbe), 32'(m_cbe));
                chk("R4/R5 idsel", 32'(ap_idsel), 32'(m_idsel));
            end
        end
    end

    task automatic host_op(input logic sel, input logic wr, input logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_sel_data = sel; host_we = wr; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_wdata = '0;
    endtask

    task automatic release_busy(input int delay);
        repeat (delay) @(negedge clk);
        ds_ack = 1'b1;
        @(negedge clk);
        ds_ack = 1'b0;
    endtask

    task automatic cfg_access(input logic [31:0] w, input logic wr, input int delay);
        host_op(1'b0, 1'b1, w);
        host_op(1'b1, wr, 32'hA5A5_0000);
        release_busy(delay);
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: stored word reads back as zero after reset
        host_op(1'b0, 1'b0, '0);
        // R10: write and read back the word, no cycle created
        host_op(1'b0, 1'b1, 32'h8000_5A0C);
        host_op(1'b0, 1'b0, '0);
        // R3/R8: type 0 read and write, nonzero low bits dropped
        cfg_access(32'h8000_5A0F, 1'b0, 0);
        cfg_access(32'h8000_5A0E, 1'b1, 2);
        // R4/R5: sweep every device value
        for (int d = 0; d < 32; d++) begin
            cfg_access(32'h8000_0000 | (d << 11) | ((d % 8) << 8) | ((d * 2) << 2), d[0], d % 3);
        end
        // R6: forwarded configuration
        cfg_access(32'h8012_3456, 1'b0, 1);
        cfg_access(32'h80FF_FFFC, 1'b1, 0);
        // R7: special cycle pattern for write, then read
        cfg_access(32'h8000_FF00, 1'b1, 0);
        cfg_access(32'h8000_FF00, 1'b0, 0);
        // R2: translation off gives I/O pass-through
        cfg_access(32'h0000_5800, 1'b0, 0);
        cfg_access(32'h0012_FF00, 1'b1, 3);
        // R11: spare bits stored and read back, translation unchanged
        cfg_access(32'hFF00_5904, 1'b0, 0);
        host_op(1'b0, 1'b0, '0);
        // R9: requests while busy are dropped; idle ds_ack ignored
        host_op(1'b0, 1'b1, 32'h8000_6000);
        host_op(1'b1, 1'b0, '0);
        host_op(1'b0, 1'b1, 32'h1234_5678);
        host_op(1'b1, 1'b1, '0);
        release_busy(1);
        ds_ack = 1'b1; @(negedge clk); ds_ack = 1'b0;
        host_op(1'b0, 1'b0, '0);
        host_op(1'b1, 1'b1, '0);
        release_busy(0);
        // mixed traffic
        for (int i = 0; i < 60; i++) begin
            logic [31:0] w;
            w = $urandom;
            if (i % 3 == 0) w[23:16] = 8'h00;
            cfg_access(w, w[0], i % 4);
            if (i % 5 == 0) host_op(1'b0, 1'b0, '0);
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule